// File: doc/BRIEF.md
# Flash Erase Suspend Arbiter

This block shares one serial-flash command sequencer between two masters: a cache refill port that fetches short reads, and a software port that can start a read, a page program or a sector erase. Short software operations simply run to completion while any cache request waits. An erase is different. It is driven by repeated status polls, and when the cache needs data from outside the sector being erased, the arbiter suspends the erase. It then polls until the flash reports the suspended state, serves every queued cache read, resumes the erase and continues polling.

The flash side is an abstract sequencer. The arbiter presents an opcode, an address and a length with a one-cycle start pulse. The sequencer answers with a one-cycle done pulse, together with a 16-bit status word or a read data word. A programmable minimum number of cycles must pass between a resume and the next suspend, so that the erase keeps making progress under steady cache traffic.

Top module: `flash_susp_arb`

## Requirements
- R1: After reset `q_start`, `c_done`, `s_done` and `s_refused` are low and `s_ready` is high.
- R2: A software read (`s_op`=00, opcode 0x03) or program (`s_op`=01, opcode 0x02) runs to completion. A cache request raised meanwhile is served only after `s_done`, and no suspend opcode is issued.
- R3: A software erase (`s_op`=1x) issues opcode 0x20, then polls status with opcode 0x05. `s_done` pulses only after a status word with bit 0 (busy) clear.
- R4: A cache request whose sector differs from the erase sector, raised while the erase is being polled, causes suspend opcode 0x75 to be issued.
- R5: After 0x75, status is re-polled until bit 15 (suspended) is set. No cache read is issued before that.
- R6: While suspended, cache requests presented back to back are all served under one suspend, with no resume between them.
- R7: Resume opcode 0x7A is issued once no cache request is pending, and every suspend of a completed erase is matched by one resume.
- R8: A cache request in the sector under erase (same address bits above `SECT_W`) is never served while the erase is active. It is served after `s_done`.
- R9: After a resume completes, no suspend opcode is issued until at least `cfg_min_gap` cycles have passed.
- R10: A software request is taken only while `s_ready` is high. Otherwise `s_refused` pulses one cycle later and no command is issued, which includes a new erase while another is suspended.
- R11: If the post-suspend status shows neither busy nor suspended, the erase has finished. `s_done` pulses and no resume is issued.
- R12: Cache reads return the sequencer data on `c_rdata` with a one-cycle `c_done`. Software reads return it on `s_rdata` with `s_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| c_req | input | 1 | Cache read request, held until `c_done` |
| c_addr | input | AW | Cache read address |
| c_done | output | 1 | Cache read finished, data valid |
| c_rdata | output | DW | Cache read data |
| s_req | input | 1 | Software command request pulse |
| s_op | input | 2 | 00 read, 01 program, 1x sector erase |
| s_addr | input | AW | Software command address |
| s_len | input | LW | Software read/program length |
| s_ready | output | 1 | Software port can accept a request |
| s_done | output | 1 | Software command finished |
| s_refused | output | 1 | Previous-cycle request was rejected |
| s_rdata | output | DW | Software read data |
| cfg_min_gap | input | GW | Minimum cycles from resume to next suspend |
| q_start | output | 1 | Sequencer command start pulse |
| q_opcode | output | 8 | Sequencer opcode |
| q_addr | output | AW | Sequencer address |
| q_len | output | LW | Sequencer data length |
| q_done | input | 1 | Sequencer command finished |
| q_status | input | 16 | Status word returned by opcode 0x05 |
| q_rdata | input | DW | Read data returned by opcode 0x03 |

## Verification
The arbiter state decides which opcode comes out next. A wrong state therefore shows up on the sequencer port within one command time: a 0x03 issued before the suspended flag has been seen, a 0x75 issued inside the re-suspend window, or a missing 0x7A. The bench's flash model counts these events and flags reads that reach the erased sector or arrive while the flash is not suspended. The order of `c_done` and `s_done`, and the data they carry, show a request that was held too long or served too early.

// File: rtl/flash_susp_pkg.sv
package flash_susp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SW,
    ST_ER_CMD,
    ST_ER_POLL,
    ST_SUS_CMD,
    ST_SUS_POLL,
    ST_SUSP,
    ST_CREAD,
    ST_RES_CMD
  } arb_state_t;

  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_PROG    = 8'h02;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_RDSR    = 8'h05;
  localparam logic [7:0] OP_SUSPEND = 8'h75;
  localparam logic [7:0] OP_RESUME  = 8'h7A;

  localparam int SR_WIP = 0;
  localparam int SR_SUS = 15;

endpackage

// File: rtl/fsa_gap_timer.sv
module fsa_gap_timer #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [GW-1:0] limit,
  output logic          open
);
  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= limit;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign open = (cnt == '0);
endmodule

// File: rtl/fsa_region_match.sv
module fsa_region_match #(
  parameter int TW = 12
) (
  input  logic          live,
  input  logic [TW-1:0] tag_a,
  input  logic [TW-1:0] tag_b,
  output logic          hit
);
  assign hit = live && (tag_a == tag_b);
endmodule

// File: rtl/flash_susp_arb.sv
module flash_susp_arb
  import flash_susp_pkg::*;
#(
  parameter int AW     = 24,
  parameter int DW     = 32,
  parameter int LW     = 9,
  parameter int GW     = 8,
  parameter int SECT_W = 12,
  parameter int RD_LEN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          c_req,
  input  logic [AW-1:0] c_addr,
  output logic          c_done,
  output logic [DW-1:0] c_rdata,
  input  logic          s_req,
  input  logic [1:0]    s_op,
  input  logic [AW-1:0] s_addr,
  input  logic [LW-1:0] s_len,
  output logic          s_ready,
  output logic          s_done,
  output logic          s_refused,
  output logic [DW-1:0] s_rdata,
  input  logic [GW-1:0] cfg_min_gap,
  output logic          q_start,
  output logic [7:0]    q_opcode,
  output logic [AW-1:0] q_addr,
  output logic [LW-1:0] q_len,
  input  logic          q_done,
  input  logic [15:0]   q_status,
  input  logic [DW-1:0] q_rdata
);
  localparam int TW = AW - SECT_W;
  localparam logic [LW-1:0] LEN_SR = LW'(2);
  localparam logic [LW-1:0] LEN_RD = LW'(RD_LEN);

  arb_state_t    st;
  logic          busy, held, er_run, sw_rd;
  logic [TW-1:0] er_tag;
  logic          pend, c_in_sect, gap_open, gap_load;
  logic          fire;
  logic [7:0]    f_op;
  logic [AW-1:0] f_addr;
  logic [LW-1:0] f_len;
  logic          unused_status;

  assign unused_status = ^q_status[14:1];
  assign pend     = c_req && !c_done;
  assign s_ready  = (st == ST_IDLE) && !pend;
  assign gap_load = (st == ST_RES_CMD) && busy && q_done;

  fsa_region_match #(.TW(TW)) u_rgn (
    .live  (er_run),
    .tag_a (c_addr[AW-1:SECT_W]),
    .tag_b (er_tag),
    .hit   (c_in_sect)
  );

  fsa_gap_timer #(.GW(GW)) u_gap (
    .clk   (clk),
    .rst   (rst),
    .load  (gap_load),
    .limit (cfg_min_gap),
    .open  (gap_open)
  );

  // Next command selection
  always_comb begin
    fire   = 1'b0;
    f_op   = OP_RDSR;
    f_addr = '0;
    f_len  = LEN_SR;
    case (st)
      ST_IDLE: begin
        if (pend) begin
          fire = 1'b1; f_op = OP_READ; f_addr = c_addr; f_len = LEN_RD;
        end else if (s_req) begin
          fire = 1'b1; f_addr = s_addr; f_len = s_len;
          if (s_op[1]) begin
            f_op = OP_ERASE; f_len = '0;
          end else if (s_op[0]) begin
            f_op = OP_PROG;
          end else begin
            f_op = OP_READ;
          end
        end
      end
      ST_ER_POLL, ST_SUS_POLL: fire = !busy;
      ST_SUS_CMD: begin fire = !busy; f_op = OP_SUSPEND; f_len = '0; end
      ST_RES_CMD: begin fire = !busy; f_op = OP_RESUME;  f_len = '0; end
      ST_SUSP: begin
        if (!c_done && pend && !c_in_sect) begin
          fire = 1'b1; f_op = OP_READ; f_addr = c_addr; f_len = LEN_RD;
        end
      end
      default: ;
    endcase
  end

  // Arbitration state and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      busy      <= 1'b0;
      held      <= 1'b0;
      er_run    <= 1'b0;
      sw_rd     <= 1'b0;
      er_tag    <= '0;
      q_start   <= 1'b0;
      q_opcode  <= '0;
      q_addr    <= '0;
      q_len     <= '0;
      c_done    <= 1'b0;
      c_rdata   <= '0;
      s_done    <= 1'b0;
      s_rdata   <= '0;
      s_refused <= 1'b0;
    end else begin
      q_start   <= fire;
      c_done    <= 1'b0;
      s_done    <= 1'b0;
      s_refused <= s_req && !s_ready;
      if (fire) begin
        q_opcode <= f_op;
        q_addr   <= f_addr;
        q_len    <= f_len;
        busy     <= 1'b1;
      end
      case (st)
        ST_IDLE: begin
          if (pend) begin
            st <= ST_CREAD;
          end else if (s_req) begin
            if (s_op[1]) begin
              st     <= ST_ER_CMD;
              er_run <= 1'b1;
              er_tag <= s_addr[AW-1:SECT_W];
            end else begin
              st    <= ST_SW;
              sw_rd <= !s_op[0];
            end
          end
        end
        ST_SW: if (q_done) begin
          busy   <= 1'b0;
          s_done <= 1'b1;
          if (sw_rd) s_rdata <= q_rdata;
          st     <= ST_IDLE;
        end
        ST_ER_CMD: if (q_done) begin
          busy <= 1'b0;
          st   <= ST_ER_POLL;
        end
        ST_ER_POLL: if (busy && q_done) begin
          busy <= 1'b0;
          if (!q_status[SR_WIP]) begin
            s_done <= 1'b1;
            er_run <= 1'b0;
            st     <= ST_IDLE;
          end else if (pend && !c_in_sect && gap_open) begin
            st <= ST_SUS_CMD;
          end
        end
        ST_SUS_CMD: if (busy && q_done) begin
          busy <= 1'b0;
          st   <= ST_SUS_POLL;
        end
        ST_SUS_POLL: if (busy && q_done) begin
          busy <= 1'b0;
          if (q_status[SR_SUS]) begin
            held <= 1'b1;
            st   <= ST_SUSP;
          end else if (!q_status[SR_WIP]) begin
            s_done <= 1'b1;
            er_run <= 1'b0;
            st     <= ST_IDLE;
          end
        end
        ST_SUSP: if (!c_done) begin
          if (pend && !c_in_sect) begin
            st <= ST_CREAD;
          end else begin
            held <= 1'b0;
            st   <= ST_RES_CMD;
          end
        end
        ST_CREAD: if (q_done) begin
          busy    <= 1'b0;
          c_done  <= 1'b1;
          c_rdata <= q_rdata;
          st      <= held ? ST_SUSP : ST_IDLE;
        end
        ST_RES_CMD: if (busy && q_done) begin
          busy <= 1'b0;
          st   <= ST_ER_POLL;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
    q_start |=> !q_start); // R3
  AST_READ_AFTER_SUS: assert property (@(posedge clk) disable iff (rst)
    (q_start && q_opcode == OP_READ && er_run) |-> held); // R5
  AST_SUS_GAP: assert property (@(posedge clk) disable iff (rst)
    (q_start && q_opcode == OP_SUSPEND) |-> gap_open); // R9
  AST_READ_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (q_start && q_opcode == OP_READ && er_run) |-> (q_addr[AW-1:SECT_W] != er_tag)); // R8
  AST_REFUSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    s_refused |-> $past(s_req)); // R10

endmodule

// File: tb/flash_susp_arb_tb.sv
`timescale 1ns/1ps
module flash_susp_arb_tb;
  localparam int AW = 24, DW = 32, LW = 9, GW = 8, SECT_W = 12, RD_LEN = 4;
  localparam int LAT = 3;
  localparam logic [DW-1:0] KEY = 32'h5A5A_0F0F;
  localparam logic [AW-1:0] ER_ADDR = 24'h010000;
  localparam logic [AW-1:0] SW_ADDR = 24'h000100;

  logic clk = 0, rst = 1;
  logic c_req = 0; logic [AW-1:0] c_addr = '0;
  logic c_done; logic [DW-1:0] c_rdata;
  logic s_req = 0; logic [1:0] s_op = '0; logic [AW-1:0] s_addr = '0; logic [LW-1:0] s_len = '0;
  logic s_ready, s_done, s_refused; logic [DW-1:0] s_rdata;
  logic [GW-1:0] cfg_min_gap = '0;
  logic q_start; logic [7:0] q_opcode; logic [AW-1:0] q_addr; logic [LW-1:0] q_len;
  logic q_done = 0; logic [15:0] q_status = '0; logic [DW-1:0] q_rdata = '0;

  flash_susp_arb #(.AW(AW), .DW(DW), .LW(LW), .GW(GW), .SECT_W(SECT_W), .RD_LEN(RD_LEN)) u_dut (
    .clk(clk), .rst(rst), .c_req(c_req), .c_addr(c_addr), .c_done(c_done), .c_rdata(c_rdata),
    .s_req(s_req), .s_op(s_op), .s_addr(s_addr), .s_len(s_len), .s_ready(s_ready),
    .s_done(s_done), .s_refused(s_refused), .s_rdata(s_rdata), .cfg_min_gap(cfg_min_gap),
    .q_start(q_start), .q_opcode(q_opcode), .q_addr(q_addr), .q_len(q_len),
    .q_done(q_done), .q_status(q_status), .q_rdata(q_rdata));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Flash model
  int cnt = 0, er_left = 0, cfg_polls = 0, sus_wait = 0;
  bit er_on = 0, sus_on = 0, sus_pend = 0, fin_on_sus = 0, had_res = 0;
  logic [7:0] m_op; logic [AW-1:0] m_addr; logic [AW-SECT_W-1:0] er_sect;
  int n_susp, n_res, n_erase, n_cread_sus, viol, min_gap_seen, t_res;

  task automatic respond();
    logic [15:0] sr;
    sr = '0;
    case (m_op)
      8'h03: begin
        q_rdata = DW'(m_addr) ^ KEY;
        if (er_on) begin
          if (!sus_on) viol++;
          if (m_addr[AW-1:SECT_W] == er_sect) viol++;
          if (sus_on) n_cread_sus++;
        end
      end
      8'h20: begin
        er_on = 1; er_left = cfg_polls; er_sect = m_addr[AW-1:SECT_W];
        n_erase++; sus_on = 0; sus_pend = 0;
      end
      8'h75: begin
        n_susp++;
        if (had_res && (cyc - t_res) < min_gap_seen) min_gap_seen = cyc - t_res;
        if (fin_on_sus) er_left = 0;
        else if (er_on && er_left > 0) begin sus_pend = 1; sus_wait = 1; end
      end
      8'h7A: begin
        n_res++; sus_on = 0; sus_pend = 0; t_res = cyc; had_res = 1;
      end
      8'h05: begin
        if (er_on) begin
          if (sus_pend) begin
            if (sus_wait > 0) begin sus_wait--; sr[0] = 1; end
            else begin sus_on = 1; sus_pend = 0; sr[0] = 1; sr[15] = 1; end
          end else if (sus_on) begin
            sr[0] = 1; sr[15] = 1;
          end else if (er_left > 0) begin
            er_left--; sr[0] = 1;
          end else begin
            er_on = 0;
          end
        end
        q_status = sr;
      end
      default: ;
    endcase
  endtask

  always @(negedge clk) begin
    q_done = 0;
    if (rst) cnt = 0;
    else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin respond(); q_done = 1; end
    end else if (q_start) begin
      m_op = q_opcode; m_addr = q_addr; cnt = LAT;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic clr_model();
    n_susp = 0; n_res = 0; n_erase = 0; n_cread_sus = 0; viol = 0;
    had_res = 0; min_gap_seen = 1000000; fin_on_sus = 0;
  endtask

  task automatic sw_go(input logic [1:0] op, input logic [AW-1:0] a);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_req = 1; s_op = op; s_addr = a; s_len = LW'(4);
    @(negedge clk);
    s_req = 0;
  endtask

  task automatic wait_sdone(output int t);
    do @(negedge clk); while (!s_done);
    t = cyc;
  endtask

  task automatic c_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int t);
    c_req = 1; c_addr = a;
    do @(negedge clk); while (!c_done);
    d = c_rdata; t = cyc;
  endtask

  // op, cache address, delay, erase polls, expected suspends, cache first
  typedef struct packed {
    logic [1:0]  op;
    logic [23:0] caddr;
    logic [7:0]  dly;
    logic [7:0]  polls;
    logic [3:0]  nsus;
    logic        cfirst;
  } vec_t;
  localparam int NV = 5;
  localparam logic [46:0] VECS [NV] = '{
    {2'd0, 24'h020100, 8'd1,  8'd0,  4'd0, 1'b0},
    {2'd1, 24'h000040, 8'd1,  8'd0,  4'd0, 1'b0},
    {2'd2, 24'h030000, 8'd3,  8'd12, 4'd1, 1'b1},
    {2'd2, 24'h010800, 8'd3,  8'd12, 4'd0, 1'b0},
    {2'd2, 24'h0FF000, 8'd30, 8'd25, 4'd1, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end

  initial begin
    vec_t v;
    int ts, tc, ts2;
    logic [DW-1:0] cd;
    bit sd_er;
    clr_model();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(q_start == 0, "R1 q_start", q_start, 0);
    chk(s_ready == 1, "R1 s_ready", s_ready, 1);
    chk(c_done == 0 && s_done == 0, "R1 done", {c_done, s_done}, 0);
    chk(s_refused == 0, "R1 s_refused", s_refused, 0);

    for (int i = 0; i < NV; i++) begin
      v = vec_t'(VECS[i]);
      clr_model();
      cfg_polls = int'(v.polls);
      ts = 0; tc = 0; cd = '0; sd_er = 0;
      fork
        begin
          sw_go(v.op, v.op[1] ? ER_ADDR : SW_ADDR);
          wait_sdone(ts);
          sd_er = er_on;
          if (v.op == 2'd0) chk(s_rdata == (DW'(SW_ADDR) ^ KEY), "R12 sw data", s_rdata, DW'(SW_ADDR) ^ KEY);
        end
        begin
          repeat (int'(v.dly) + 1) @(negedge clk);
          c_read(v.caddr, cd, tc);
          c_req = 0;
        end
      join
      repeat (4) @(negedge clk);
      chk(cd == (DW'(v.caddr) ^ KEY), "R12 cache data", cd, DW'(v.caddr) ^ KEY);
      chk(viol == 0, "R5 R8 read during erase", viol, 0);
      if (!v.op[1]) begin
        chk(n_susp == 0 && tc > ts, "R2 stall", n_susp, 0);
      end else if (v.nsus != 0) begin
        chk(n_susp == int'(v.nsus) && tc < ts, "R4 suspend", n_susp, v.nsus);
        chk(n_res == n_susp, "R7 resume", n_res, n_susp);
        chk(!sd_er, "R3 done after busy clear", sd_er, 0);
      end else begin
        chk(n_susp == 0 && tc > ts, "R8 in-sector hold", n_susp, 0);
        chk(!sd_er, "R3 done after busy clear", sd_er, 0);
      end
    end

    // R6: back-to-back reads under one suspend
    clr_model(); cfg_polls = 20;
    fork
      begin sw_go(2'd2, ER_ADDR); wait_sdone(ts); end
      begin
        repeat (4) @(negedge clk);
        for (int k = 0; k < 3; k++) c_read(24'h040000 + AW'(k * 16), cd, tc);
        c_req = 0;
      end
    join
    repeat (4) @(negedge clk);
    chk(n_susp == 1, "R6 one suspend", n_susp, 1);
    chk(n_cread_sus == 3, "R6 reads in suspend", n_cread_sus, 3);
    chk(viol == 0, "R5 confirm before read", viol, 0);

    // R10: erase request while suspended is refused
    clr_model(); cfg_polls = 20;
    fork
      begin sw_go(2'd2, ER_ADDR); wait_sdone(ts); end
      begin
        repeat (4) @(negedge clk);
        c_req = 1; c_addr = 24'h050000;
        do @(negedge clk); while (!sus_on);
        s_req = 1; s_op = 2'd2; s_addr = 24'h070000;
        @(negedge clk);
        s_req = 0;
        chk(s_refused == 1, "R10 refused", s_refused, 1);
        while (!c_done) @(negedge clk);
        c_req = 0;
      end
    join
    repeat (4) @(negedge clk);
    chk(n_erase == 1, "R10 no second erase", n_erase, 1);

    // R9: minimum gap from resume to next suspend
    clr_model(); cfg_polls = 40; cfg_min_gap = GW'(40);
    fork
      begin sw_go(2'd2, ER_ADDR); wait_sdone(ts); end
      begin
        repeat (4) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
          c_read(24'h060000 + AW'(k * 32), cd, tc);
          c_req = 0;
          repeat (3) @(negedge clk);
        end
      end
    join
    repeat (4) @(negedge clk);
    chk(n_susp >= 2, "R9 resuspend", n_susp, 2);
    chk(min_gap_seen >= 40, "R9 gap", min_gap_seen, 40);
    cfg_min_gap = '0;

    // R11: erase completes as the suspend lands
    clr_model(); cfg_polls = 20; fin_on_sus = 1;
    ts2 = 0;
    fork
      begin sw_go(2'd2, ER_ADDR); wait_sdone(ts2); end
      begin
        repeat (4) @(negedge clk);
        c_read(24'h070000, cd, tc);
        c_req = 0;
      end
    join
    repeat (4) @(negedge clk);
    chk(n_susp == 1 && n_res == 0, "R11 no resume", n_res, 0);
    chk(tc > ts2, "R11 cache after done", tc, ts2);
    chk(cd == (DW'(24'h070000) ^ KEY), "R12 cache data", cd, DW'(24'h070000) ^ KEY);

    summary();
  end
endmodule